// File: doc/BRIEF.md
# Mixed-Type Interrupt Source Controller

This block gathers seven interrupt sources whose behaviour differs and shows them to a processor as one status word. Three sources are plain levels from pins: two active-low and one active-high. Their status bits follow the pin and drop only when the pin goes idle. A media-change pin is sampled on a slow sample tick and must hold high over two consecutive samples before its filtered copy rises. The rising edge of that filtered copy latches a bit that drives the fast interrupt output. A codec FIFO threshold event and two timer underflow events are latched as well. Each timer event is held back until the next falling edge of that timer's own clock.

Every pin first passes through a two-flop synchronizer into the system clock domain. Software uses a small register bus. It reads raw and masked status, writes a per-source mask, and writes per-source end-of-interrupt addresses to clear latched bits. The normal interrupt output is the masked OR of every source except media change. The fast interrupt output is the masked media-change bit. Both outputs are registered.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset, raw status, mask, masked status, `rd_data`, `irq` and `fiq` are all zero.
- R2: Status bit 0 is set while `ext1_n` is low and bit 1 while `ext2_n` is low. Each bit clears only when its pin returns high.
- R3: Status bit 2 is set while `ext3` is high and clears only when the pin returns low.
- R4: The end-of-interrupt addresses of the level sources (8, 9 and 10 for bits 0, 1 and 2) do not change their status bits.
- R5: The media-change bit (bit 6) can only set once `media_pin` has been seen high on two consecutive `sample_tick` pulses. A pin high for one sample only does not set it.
- R6: Bit 6 latches on the rising edge of the filtered media signal. It stays set while the pin stays high and clears only on a write to address 14. It does not set again until a new filtered rising edge.
- R7: Codec bit 3 latches on a rising edge of `codec_half` when `codec_dir` is 1 (transmit), or of `codec_empty` when `codec_dir` is 0 (receive). The condition that is not selected has no effect. A write to address 11 clears the bit.
- R8: After a rising edge on `tmr_zero[t]`, timer bit 4+t sets only on the next falling edge of `tmr_clk[t]`. A rising clock edge does not set it. A write to address 12+t clears it, and a later falling edge with no new underflow does not set it again.
- R9: If a set event for a latched bit and the write to its end-of-interrupt address land in the same cycle, the bit stays set.
- R10: Address 1 holds the mask (bit i enables source i) and reads back. `irq` is the registered OR of the masked bits 0 to 5. `fiq` is the registered masked bit 6. Both outputs are zero while the mask is zero.
- R11: A read with `rd_en` returns data on `rd_data` one cycle later. Address 0 returns raw status, address 1 the mask, address 2 the masked status, and any other address zero. `rd_data` is zero in every cycle that follows a cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_tick | input | 1 | One-cycle pulse that paces the media-change filter |
| media_pin | input | 1 | Asynchronous media-change pin, active high |
| ext1_n | input | 1 | External level interrupt 1, active low |
| ext2_n | input | 1 | External level interrupt 2, active low |
| ext3 | input | 1 | External level interrupt 3, active high |
| codec_dir | input | 1 | Codec direction: 1 transmit (half-full), 0 receive (empty) |
| codec_half | input | 1 | Codec FIFO half-full flag |
| codec_empty | input | 1 | Codec FIFO empty flag |
| tmr_clk | input | 2 | Clock of each timer |
| tmr_zero | input | 2 | Underflow flag of each timer |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
The bench places an end-of-interrupt write in the exact cycle the codec edge reaches the status register. A design that let the clear win would lose that interrupt. It sends the media pin high for a single sample and then for two. A filter that is too short would raise the fast interrupt on a glitch. It raises a timer underflow and then holds the timer clock high for many cycles before dropping it. A design that set the bit at once, or on a rising clock edge, shows the bit too early. The bench also writes clear addresses to the level sources, keeps the codec flag high after a clear, and switches the codec direction. A design that cleared levels, re-triggered on a level, or watched the wrong FIFO flag would show a status bit that should not be there.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_SRC   = 7;
  localparam int NUM_TMR   = 2;
  localparam int SRC_EXT1  = 0;
  localparam int SRC_EXT2  = 1;
  localparam int SRC_EXT3  = 2;
  localparam int SRC_CODEC = 3;
  localparam int SRC_TMR0  = 4;
  localparam int SRC_MEDIA = 6;

  localparam int ADR_STATUS = 0;
  localparam int ADR_MASK   = 1;
  localparam int ADR_PEND   = 2;
  localparam int ADR_EOI    = 8;

  function automatic logic src_is_level(input int idx);
    return (idx == SRC_EXT1) || (idx == SRC_EXT2) || (idx == SRC_EXT3);
  endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irqc_deglitch.sv
module irqc_deglitch #(
  parameter int N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic filt
);
  logic [N-1:0] hist;
  logic [N-1:0] hist_nxt;

  assign hist_nxt = {hist[N-2:0], din};

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      filt <= 1'b0;
    end else if (tick) begin
      hist <= hist_nxt;
      if (&hist_nxt)       filt <= 1'b1;
      else if (~|hist_nxt) filt <= 1'b0;
    end
  end

  // R5: the filtered level moves only on a sample tick
  assert_filt_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt) |-> $past(tick));
  // R5: filtered level rises only when the sampled pin was high
  assert_filt_rise_src_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(filt) |-> $past(din));
endmodule

// File: rtl/irqc_tmr_align.sv
module irqc_tmr_align (
  input  logic clk,
  input  logic rst,
  input  logic tclk_s,
  input  logic zero_s,
  output logic evt
);
  logic zero_prev;
  logic clk_prev;
  logic pending;
  logic zero_rise;
  logic clk_fall;

  assign zero_rise = zero_s & ~zero_prev;
  assign clk_fall  = clk_prev & ~tclk_s;
  assign evt       = pending & clk_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_prev <= 1'b0;
      clk_prev  <= 1'b0;
      pending   <= 1'b0;
    end else begin
      zero_prev <= zero_s;
      clk_prev  <= tclk_s;
      if (zero_rise)     pending <= 1'b1;
      else if (clk_fall) pending <= 1'b0;
    end
  end

  // R8: a re-timed underflow is a single-cycle pulse
  assert_tmr_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    evt |=> !evt);
endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter int FILT_SAMPLES = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sample_tick,
  input  logic               media_pin,
  input  logic               ext1_n,
  input  logic               ext2_n,
  input  logic               ext3,
  input  logic               codec_dir,
  input  logic               codec_half,
  input  logic               codec_empty,
  input  logic [NUM_TMR-1:0] tmr_clk,
  input  logic [NUM_TMR-1:0] tmr_zero,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq,
  output logic               fiq
);
  localparam int SYNC_W = 7 + 2 * NUM_TMR;
  localparam logic [NUM_SRC-1:0] IRQ_SEL = ~(NUM_SRC'(1) << SRC_MEDIA);

  // synchronized, all active high
  logic [SYNC_W-1:0] raw_in;
  logic [SYNC_W-1:0] syn;
  logic media_s, ext1_s, ext2_s, ext3_s, dir_s, half_s, empty_s;
  logic [NUM_TMR-1:0] tclk_s, tzero_s;

  assign raw_in = {tzero_s_src(tmr_zero), tmr_clk, codec_empty, codec_half,
                   codec_dir, ext3, ~ext2_n, ~ext1_n, media_pin};

  function automatic logic [NUM_TMR-1:0] tzero_s_src(input logic [NUM_TMR-1:0] v);
    return v;
  endfunction

  irqc_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn)
  );

  assign media_s = syn[0];
  assign ext1_s  = syn[1];
  assign ext2_s  = syn[2];
  assign ext3_s  = syn[3];
  assign dir_s   = syn[4];
  assign half_s  = syn[5];
  assign empty_s = syn[6];
  assign tclk_s  = syn[7 +: NUM_TMR];
  assign tzero_s = syn[7 + NUM_TMR +: NUM_TMR];

  // media change filter and edge
  logic media_filt, media_filt_q;
  irqc_deglitch #(.N(FILT_SAMPLES)) u_deglitch (
    .clk(clk), .rst(rst), .tick(sample_tick), .din(media_s), .filt(media_filt)
  );

  // codec threshold edge
  logic codec_sel, codec_q;
  assign codec_sel = dir_s ? half_s : empty_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      media_filt_q <= 1'b0;
      codec_q      <= 1'b0;
    end else begin
      media_filt_q <= media_filt;
      codec_q      <= codec_sel;
    end
  end

  // timer re-timing
  logic [NUM_TMR-1:0] tmr_evt;
  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    irqc_tmr_align u_align (
      .clk(clk), .rst(rst), .tclk_s(tclk_s[t]), .zero_s(tzero_s[t]),
      .evt(tmr_evt[t])
    );
  end

  // per-source set events, levels and clears
  logic [NUM_SRC-1:0] set_evt, lvl, eoi, status, mask, pend;

  always_comb begin
    set_evt            = '0;
    set_evt[SRC_CODEC] = codec_sel & ~codec_q;
    set_evt[SRC_MEDIA] = media_filt & ~media_filt_q;
    for (int t = 0; t < NUM_TMR; t++) set_evt[SRC_TMR0 + t] = tmr_evt[t];
    lvl           = '0;
    lvl[SRC_EXT1] = ext1_s;
    lvl[SRC_EXT2] = ext2_s;
    lvl[SRC_EXT3] = ext3_s;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign eoi[i] = wr_en && (addr == ADDR_W'(ADR_EOI + i));
    if (src_is_level(i)) begin : g_level
      always_ff @(posedge clk) begin
        if (rst) status[i] <= 1'b0;
        else     status[i] <= lvl[i];
      end
    end else begin : g_latch
      always_ff @(posedge clk) begin
        if (rst) status[i] <= 1'b0;
        else     status[i] <= set_evt[i] | (status[i] & ~eoi[i]);
      end
      // R6: a latched bit holds until its own clear address is written
      assert_latch_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (status[i] && !eoi[i]) |=> status[i]);
      // R9: a set event wins over a clear in the same cycle
      assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        set_evt[i] |=> status[i]);
    end
  end

  // mask register
  always_ff @(posedge clk) begin
    if (rst)                                       mask <= '0;
    else if (wr_en && addr == ADDR_W'(ADR_MASK))   mask <= wr_data[NUM_SRC-1:0];
  end

  assign pend = status & mask;

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
      fiq <= 1'b0;
    end else begin
      irq <= |(pend & IRQ_SEL);
      fiq <= pend[SRC_MEDIA];
    end
  end

  // read port
  always_ff @(posedge clk) begin
    if (rst || !rd_en) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      if (addr == ADDR_W'(ADR_STATUS))    rd_data[NUM_SRC-1:0] <= status;
      else if (addr == ADDR_W'(ADR_MASK)) rd_data[NUM_SRC-1:0] <= mask;
      else if (addr == ADDR_W'(ADR_PEND)) rd_data[NUM_SRC-1:0] <= pend;
    end
  end

  // R10: with an all-zero mask neither output is raised
  assert_mask_gates_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(|mask) |-> (!irq && !fiq));
  // R10: fast output needs the media mask bit
  assert_fiq_mask_R10: assert property (@(posedge clk) disable iff (rst)
    fiq |-> $past(mask[SRC_MEDIA]));
  // R11: no read strobe, no read data
  assert_rd_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> (rd_data == '0));
endmodule

// File: tb/test_irq_source_ctrl.sv
module test_irq_source_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sample_tick = 1'b0, media_pin = 1'b0;
  logic       ext1_n = 1'b1, ext2_n = 1'b1, ext3 = 1'b0;
  logic       codec_dir = 1'b1, codec_half = 1'b0, codec_empty = 1'b0;
  logic [1:0] tmr_clk = 2'b11, tmr_zero = 2'b00;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq, fiq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_source_ctrl i_irq_source_ctrl (
    .clk(clk), .rst(rst), .sample_tick(sample_tick), .media_pin(media_pin),
    .ext1_n(ext1_n), .ext2_n(ext2_n), .ext3(ext3), .codec_dir(codec_dir),
    .codec_half(codec_half), .codec_empty(codec_empty), .tmr_clk(tmr_clk),
    .tmr_zero(tmr_zero), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq), .fiq(fiq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic tick();
    @(negedge clk); sample_tick = 1'b1;
    @(negedge clk); sample_tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    bus_rd(4'd0, d); check("R1 status", d, 8'h00);
    bus_rd(4'd1, d); check("R1 mask", d, 8'h00);
    bus_rd(4'd2, d); check("R1 pending", d, 8'h00);
    check("R1 irq/fiq", {irq, fiq}, 2'b00);
  endtask

  task automatic t_levels();
    logic [7:0] d;
    ext1_n = 1'b0; cyc(5);
    bus_rd(4'd0, d); check("R2 ext1 low", d, 8'h01);
    bus_wr(4'd8, 8'h00); cyc(2);
    bus_rd(4'd0, d); check("R4 ext1 eoi ignored", d, 8'h01);
    ext1_n = 1'b1; cyc(5);
    bus_rd(4'd0, d); check("R2 ext1 idle", d, 8'h00);
    ext2_n = 1'b0; cyc(5);
    bus_rd(4'd0, d); check("R2 ext2 low", d, 8'h02);
    bus_wr(4'd9, 8'h00); cyc(2);
    bus_rd(4'd0, d); check("R4 ext2 eoi ignored", d, 8'h02);
    ext2_n = 1'b1; cyc(5);
    bus_rd(4'd0, d); check("R2 ext2 idle", d, 8'h00);
    ext3 = 1'b1; cyc(5);
    bus_rd(4'd0, d); check("R3 ext3 high", d, 8'h04);
    bus_wr(4'd10, 8'h00); cyc(2);
    bus_rd(4'd0, d); check("R4 ext3 eoi ignored", d, 8'h04);
    ext3 = 1'b0; cyc(5);
    bus_rd(4'd0, d); check("R3 ext3 idle", d, 8'h00);
  endtask

  task automatic t_codec();
    logic [7:0] d;
    codec_dir = 1'b1; codec_empty = 1'b1; cyc(5);
    bus_rd(4'd0, d); check("R7 tx ignores empty", d, 8'h00);
    codec_empty = 1'b0; codec_half = 1'b1; cyc(5);
    bus_rd(4'd0, d); check("R7 tx half sets", d, 8'h08);
    bus_wr(4'd11, 8'h00); cyc(3);
    bus_rd(4'd0, d); check("R7 clear, no re-set on held level", d, 8'h00);
    codec_half = 1'b0; cyc(4);
    codec_dir = 1'b0; cyc(4);
    codec_half = 1'b1; cyc(5);
    bus_rd(4'd0, d); check("R7 rx ignores half", d, 8'h00);
    codec_empty = 1'b1; cyc(5);
    bus_rd(4'd0, d); check("R7 rx empty sets", d, 8'h08);
    bus_wr(4'd11, 8'h00);
    codec_empty = 1'b0; codec_half = 1'b0; codec_dir = 1'b1; cyc(5);
    bus_rd(4'd0, d); check("R7 cleared", d, 8'h00);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    @(negedge clk); codec_half = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 4'd11; wr_data = 8'h00;
    @(negedge clk); wr_en = 1'b0;
    bus_rd(4'd0, d); check("R9 set beats same-cycle clear", d, 8'h08);
    bus_wr(4'd11, 8'h00);
    bus_rd(4'd0, d); check("R9 later clear works", d, 8'h00);
    codec_half = 1'b0; cyc(4);
  endtask

  task automatic t_timer();
    logic [7:0] d;
    tmr_zero[0] = 1'b1; cyc(3); tmr_zero[0] = 1'b0; cyc(10);
    bus_rd(4'd0, d); check("R8 waits for clock fall", d, 8'h00);
    tmr_clk[0] = 1'b0; cyc(5);
    bus_rd(4'd0, d); check("R8 timer0 on fall", d, 8'h10);
    bus_wr(4'd12, 8'h00); cyc(2);
    bus_rd(4'd0, d); check("R8 timer0 clear", d, 8'h00);
    tmr_clk[0] = 1'b1; cyc(5); tmr_clk[0] = 1'b0; cyc(5);
    bus_rd(4'd0, d); check("R8 fall without underflow", d, 8'h00);
    tmr_clk[0] = 1'b0; tmr_clk[1] = 1'b0; cyc(4);
    tmr_zero[1] = 1'b1; cyc(3); tmr_zero[1] = 1'b0;
    tmr_clk[1] = 1'b1; cyc(5);
    bus_rd(4'd0, d); check("R8 rising clock does not set", d, 8'h00);
    tmr_clk[1] = 1'b0; cyc(5);
    bus_rd(4'd0, d); check("R8 timer1 on fall", d, 8'h20);
    bus_wr(4'd13, 8'h00); cyc(2);
    bus_rd(4'd0, d); check("R8 timer1 clear", d, 8'h00);
    tmr_clk = 2'b11; cyc(4);
  endtask

  task automatic t_media();
    logic [7:0] d;
    media_pin = 1'b1; cyc(4); tick();
    media_pin = 1'b0; cyc(4); tick(); tick(); cyc(3);
    bus_rd(4'd0, d); check("R5 one-sample glitch", d, 8'h00);
    media_pin = 1'b1; cyc(4); tick(); cyc(3);
    bus_rd(4'd0, d); check("R5 one sample not enough", d, 8'h00);
    tick(); cyc(3);
    bus_rd(4'd0, d); check("R5 two samples set", d, 8'h40);
    tick(); cyc(3);
    bus_rd(4'd0, d); check("R6 held while pin high", d, 8'h40);
    bus_wr(4'd14, 8'h00); tick(); cyc(3);
    bus_rd(4'd0, d); check("R6 clear, no new edge", d, 8'h00);
    media_pin = 1'b0; cyc(4); tick(); tick(); cyc(2);
  endtask

  task automatic t_outputs();
    logic [7:0] d;
    bus_wr(4'd1, 8'h44);
    bus_rd(4'd1, d); check("R10 mask readback", d, 8'h44);
    ext3 = 1'b1; cyc(6);
    check("R10 irq from ext3", {irq, fiq}, 2'b10);
    bus_rd(4'd2, d); check("R11 pending read", d, 8'h04);
    bus_rd(4'd5, d); check("R11 unmapped reads zero", d, 8'h00);
    media_pin = 1'b1; cyc(4); tick(); tick(); cyc(4);
    check("R10 fiq and irq", {irq, fiq}, 2'b11);
    bus_wr(4'd1, 8'h40); cyc(2);
    check("R10 media masked to fiq only", {irq, fiq}, 2'b01);
    bus_wr(4'd1, 8'h00); cyc(2);
    check("R10 all masked", {irq, fiq}, 2'b00);
    bus_rd(4'd0, d); check("R11 raw status", d, 8'h44);
    @(negedge clk); rd_en = 1'b1; addr = 4'd0;
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk); check("R11 data only after strobe", rd_data, 8'h00);
    ext3 = 1'b0; media_pin = 1'b0; bus_wr(4'd14, 8'h00);
    cyc(4); tick(); tick(); cyc(3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cyc(2);
    t_reset();
    t_levels();
    t_codec();
    t_set_wins();
    t_timer();
    t_media();
    t_outputs();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule